// File: doc/BRIEF.md
# Cyclic Motor Command Queue

This block holds 16-bit motor commands on their way to a bank of pattern generators. Commands enter on a valid/ready push port and leave on a valid/ready command port. The queue can run as a plain first-in first-out store. It can also run as a ring of programmable depth that replays its contents for as long as it is triggered. A transfer towards the generators is launched by one of three sources: a software pop strobe, a tick of a divided low-power clock, or a real-time-clock event. The last two each have their own enable. A single launch may release several commands. The first command of the launch carries a 3-bit count in bits [15:13] that gives the number of commands following it.

Push back-pressure: `push_ready` is low while the queue is full in plain mode. A producer is expected to hold its data until ready is high. A push offered while ready is low is discarded and is reported as an overflow. In ring mode `push_ready` stays high and a push overwrites the slot at the write pointer. Pop back-pressure: once a launch is under way, `cmd_valid` and `cmd_data` hold steady until `cmd_ready` is seen high. A command leaves the queue only on a cycle where both are high. Launches that arrive while a transfer is still running are ignored.

Both pointers are visible as ports. Five conditions feed sticky status bits: overflow, underrun, low fill level, generator start and generator end. Each bit is cleared by writing 1 to its clear bit. `irq` is the OR of the status bits.

Top module: `motor_cmd_queue`

## Requirements
- R1: In plain mode (`cyc_mode`=0) commands leave on the command port in the order they were pushed, and `wr_ptr - rd_ptr` (6-bit) equals the number of stored commands.
- R2: In plain mode, with 32 commands stored, `push_ready` is 0. A push is then discarded: `wr_ptr` stays at 32 and the stored commands are unchanged. If `irq_en[0]` is set, status bit 0 (overflow) is set.
- R3: A launch in plain mode while the queue is empty produces no command. If `irq_en[1]` is set, status bit 1 (underrun) is set. A launch whose count runs past the stored commands ends the transfer when the queue empties and sets the same bit.
- R4: One launch releases `cmd[15:13]+1` commands, where `cmd` is the first command of that launch. The count bits of the commands that follow it are not used.
- R5: A launch comes from `sw_pop`, from `lp_tick` only while `lp_trig_en` is 1, or from `rtc_evt` only while `rtc_trig_en` is 1.
- R6: In ring mode (`cyc_mode`=1) both pointers wrap to 0 after `cyc_size-1`. A value of 0 in `cyc_size`, or one larger than 32, means 32. Pops never empty the ring and never raise underrun.
- R7: A write strobe on `wp_wr` loads `wp_wdata` into the write pointer only in ring mode. In plain mode it leaves `wr_ptr` unchanged.
- R8: Status bit 2 (threshold) is set on each cycle where `irq_en[2]` is 1 and the fill level `wr_ptr - rd_ptr` is at or below `thr_level`.
- R9: Status bit 3 is set when `irq_en[3]` is 1 and some generator `i` pulses `gen_start[i]` while `gen_start_msk[i]` is 1. Status bit 4 does the same for `gen_end`, `gen_end_msk` and `irq_en[4]`.
- R10: A status bit stays set until a 1 on its `irq_clr` bit clears it. If a set and a clear meet in the same cycle, the bit stays set. `irq` is the OR of the five bits.
- R11: After reset both pointers are 0, all status bits are 0 and `cmd_valid` is 0.
- R12: While `cmd_valid` is 1 and `cmd_ready` is 0, in plain mode, `cmd_valid` and `cmd_data` hold their values and `rd_ptr` does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_mode | input | 1 | 0 = plain queue, 1 = ring replay |
| cyc_size | input | 7 | Ring depth (0 or >32 means 32) |
| push_valid | input | 1 | Push offer |
| push_ready | output | 1 | Queue can accept a push |
| push_data | input | 16 | Command to push |
| cmd_valid | output | 1 | Command offered to generators |
| cmd_ready | input | 1 | Generators accept the command |
| cmd_data | output | 16 | Offered command |
| sw_pop | input | 1 | Software launch strobe |
| lp_tick | input | 1 | Divided low-power clock tick |
| lp_trig_en | input | 1 | Enable launch from lp_tick |
| rtc_evt | input | 1 | Real-time-clock event |
| rtc_trig_en | input | 1 | Enable launch from rtc_evt |
| wp_wr | input | 1 | Write-pointer load strobe |
| wp_wdata | input | 6 | Write-pointer load value |
| rd_ptr | output | 6 | Read pointer |
| wr_ptr | output | 6 | Write pointer |
| thr_level | input | 6 | Low fill-level threshold |
| irq_en | input | 5 | Enables: 0 ovf, 1 unr, 2 thr, 3 start, 4 end |
| gen_start | input | 5 | Per-generator start pulses |
| gen_end | input | 5 | Per-generator end pulses |
| gen_start_msk | input | 5 | Per-generator start contribution |
| gen_end_msk | input | 5 | Per-generator end contribution |
| irq_clr | input | 5 | Write-1 clear of status bits |
| irq_status | output | 5 | Sticky status bits |
| irq | output | 1 | OR of status bits |

## Verification
The assertions run on every cycle. They cover the stalled command holding still, the write pointer staying put on a dropped push or a locked pointer load, the ring read pointer wrapping at its programmed end, and the stickiness of each status bit, including set beating clear. Other behaviours are only visible across a sequence of pushes and launches, so only the bench scenarios show them. These are push order being preserved under random stalls, the length of a multi-command launch taken from its first command, underrun on an empty launch, the gating of the two timed trigger sources, and the ring replaying its contents.

// File: rtl/mcq_pkg.sv
package mcq_pkg;
  localparam int IRQ_N    = 5;
  localparam int IRQ_OVF  = 0;
  localparam int IRQ_UNR  = 1;
  localparam int IRQ_THR  = 2;
  localparam int IRQ_GST  = 3;
  localparam int IRQ_GEND = 4;
  // launch count field inside the first command of a launch
  localparam int CNT_LSB  = 13;
  localparam int CNT_W    = 3;
endpackage

// File: rtl/mcq_store.sv
module mcq_store #(
  parameter int CMD_W  = 16,
  parameter int PTR_W  = 6,
  parameter int SIZE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_mode,
  input  logic [SIZE_W-1:0] cyc_size,
  input  logic             push_valid,
  input  logic [CMD_W-1:0] push_data,
  input  logic             pop,
  input  logic             wp_wr,
  input  logic [PTR_W-1:0] wp_wdata,
  output logic [CMD_W-1:0] head_data,
  output logic [PTR_W-1:0] rptr,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             push_drop
);
  localparam int AW    = PTR_W - 1;
  localparam int DEPTH = 2 ** AW;

  logic [CMD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] eff_size;
  logic             push_ok;

  always_comb begin
    if (cyc_size == '0 || int'(cyc_size) > DEPTH) eff_size = PTR_W'(DEPTH);
    else                                        eff_size = PTR_W'(cyc_size);
  end

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                            input logic ring,
                                            input logic [PTR_W-1:0] sz);
    if (ring && p == sz - 1'b1) return '0;
    return p + 1'b1;
  endfunction

  assign level     = wptr - rptr;
  assign empty     = !cyc_mode && (level == '0);
  assign full      = !cyc_mode && (level == PTR_W'(DEPTH));
  assign push_ok   = push_valid && !full;
  assign push_drop = push_valid && full;
  assign head_data = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wp_wr && cyc_mode) wptr <= wp_wdata;
      else if (push_ok)      wptr <= step(wptr, cyc_mode, eff_size);
      if (pop)               rptr <= step(rptr, cyc_mode, eff_size);
    end
  end

  // R2: a discarded push leaves the write pointer where it was
  assert_drop_keeps_wptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !wp_wr) |=> $stable(wptr));

  // R7: pointer load is locked out in plain mode
  assert_wptr_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_mode && wp_wr && !push_valid) |=> $stable(wptr));

  // R6: ring read pointer returns to zero after its last slot
  assert_ring_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_mode && pop && rptr == eff_size - 1'b1) |=> (rptr == '0));
endmodule

// File: rtl/mcq_pop_seq.sv
module mcq_pop_seq
  import mcq_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_mode,
  input  logic             trig,
  input  logic             empty,
  input  logic [CMD_W-1:0] head_data,
  input  logic             cmd_ready,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_data,
  output logic             pop,
  output logic             underrun
);
  logic             busy;
  logic             first;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] cnt_now;
  logic             start;

  assign cmd_valid = busy && (cyc_mode || !empty);
  assign cmd_data  = head_data;
  assign pop       = cmd_valid && cmd_ready;
  assign start     = trig && !busy && (cyc_mode || !empty);
  assign underrun  = !cyc_mode && empty && (busy || trig);
  assign cnt_now   = first ? head_data[CNT_LSB +: CNT_W] : remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      first  <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      first <= 1'b1;
    end else if (busy) begin
      if (!cyc_mode && empty) begin
        busy <= 1'b0;
      end else if (pop) begin
        first <= 1'b0;
        if (cnt_now == '0) busy <= 1'b0;
        else               remain <= cnt_now - 1'b1;
      end
    end
  end

  // R12: a stalled command is held steady in plain mode
  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !cyc_mode) |=>
      (cyc_mode || (cmd_valid && $stable(cmd_data))));
endmodule

// File: rtl/mcq_irq_bank.sv
module mcq_irq_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (set[i]) bit_q <= 1'b1;
      else if (clr[i]) bit_q <= 1'b0;
    end
    assign status[i] = bit_q;

    // R10: sticky until cleared, set beats clear
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !clr[i]) |=> status[i]);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !status[i]);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> status[i]);
  end
endmodule

// File: rtl/motor_cmd_queue.sv
module motor_cmd_queue
  import mcq_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int PTR_W  = 6,
  parameter int SIZE_W = 7,
  parameter int NGEN   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_mode,
  input  logic [SIZE_W-1:0] cyc_size,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [CMD_W-1:0]  push_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              sw_pop,
  input  logic              lp_tick,
  input  logic              lp_trig_en,
  input  logic              rtc_evt,
  input  logic              rtc_trig_en,
  input  logic              wp_wr,
  input  logic [PTR_W-1:0]  wp_wdata,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  thr_level,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic [NGEN-1:0]   gen_start,
  input  logic [NGEN-1:0]   gen_end,
  input  logic [NGEN-1:0]   gen_start_msk,
  input  logic [NGEN-1:0]   gen_end_msk,
  input  logic [IRQ_N-1:0]  irq_clr,
  output logic [IRQ_N-1:0]  irq_status,
  output logic              irq
);
  logic [CMD_W-1:0] head_data;
  logic [PTR_W-1:0] level;
  logic             empty, full, push_drop, pop, underrun, trig;
  logic [IRQ_N-1:0] irq_set;

  assign trig       = sw_pop || (lp_tick && lp_trig_en) || (rtc_evt && rtc_trig_en);
  assign push_ready = !full;

  mcq_store #(.CMD_W(CMD_W), .PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cyc_mode(cyc_mode), .cyc_size(cyc_size),
    .push_valid(push_valid), .push_data(push_data), .pop(pop),
    .wp_wr(wp_wr), .wp_wdata(wp_wdata), .head_data(head_data),
    .rptr(rd_ptr), .wptr(wr_ptr), .level(level), .empty(empty),
    .full(full), .push_drop(push_drop)
  );

  mcq_pop_seq #(.CMD_W(CMD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cyc_mode(cyc_mode), .trig(trig),
    .empty(empty), .head_data(head_data), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .pop(pop), .underrun(underrun)
  );

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_OVF]  = irq_en[IRQ_OVF]  && push_drop;
    irq_set[IRQ_UNR]  = irq_en[IRQ_UNR]  && underrun;
    irq_set[IRQ_THR]  = irq_en[IRQ_THR]  && (level <= thr_level);
    irq_set[IRQ_GST]  = irq_en[IRQ_GST]  && |(gen_start & gen_start_msk);
    irq_set[IRQ_GEND] = irq_en[IRQ_GEND] && |(gen_end & gen_end_msk);
  end

  mcq_irq_bank #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .status(irq_status)
  );

  assign irq = |irq_status;

  // R3: an empty plain-mode launch never offers a command
  assert_empty_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_mode && empty && trig && !cmd_valid && !push_valid) |=> !cmd_valid);
endmodule

// File: tb/motor_cmd_queue_tb_top.sv
module motor_cmd_queue_tb_top;
  localparam int DEPTH = 32;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cyc_mode = 0;
  logic [6:0]  cyc_size = 0;
  logic        push_valid = 0;
  logic        push_ready;
  logic [15:0] push_data = 0;
  logic        cmd_valid;
  logic        cmd_ready = 0;
  logic [15:0] cmd_data;
  logic        sw_pop = 0, lp_tick = 0, lp_trig_en = 0, rtc_evt = 0, rtc_trig_en = 0;
  logic        wp_wr = 0;
  logic [5:0]  wp_wdata = 0;
  logic [5:0]  rd_ptr, wr_ptr;
  logic [5:0]  thr_level = 0;
  logic [4:0]  irq_en = 0;
  logic [4:0]  gen_start = 0, gen_end = 0, gen_start_msk = 0, gen_end_msk = 0;
  logic [4:0]  irq_clr = 0;
  logic [4:0]  irq_status;
  logic        irq;

  int checks = 0, fails = 0;
  logic [15:0] got [0:63];
  int got_n;
  logic [15:0] model [$];

  always #4 clk = ~clk;

  motor_cmd_queue dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_mode(cyc_mode), .cyc_size(cyc_size),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .sw_pop(sw_pop), .lp_tick(lp_tick), .lp_trig_en(lp_trig_en),
    .rtc_evt(rtc_evt), .rtc_trig_en(rtc_trig_en), .wp_wr(wp_wr), .wp_wdata(wp_wdata),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .thr_level(thr_level), .irq_en(irq_en),
    .gen_start(gen_start), .gen_end(gen_end), .gen_start_msk(gen_start_msk),
    .gen_end_msk(gen_end_msk), .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq)
  );

  function automatic int burst_len(input logic [15:0] c);
    return int'(c[15:13]) + 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cyc_mode = 0; cyc_size = 0; push_valid = 0; cmd_ready = 0;
    sw_pop = 0; lp_tick = 0; rtc_evt = 0; lp_trig_en = 0; rtc_trig_en = 0;
    wp_wr = 0; irq_en = 0; irq_clr = 0; thr_level = 0;
    gen_start = 0; gen_end = 0; gen_start_msk = 0; gen_end_msk = 0;
    model.delete();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] d);
    push_valid = 1; push_data = d;
    @(negedge clk);
    push_valid = 0;
  endtask

  // src: 0 software, 1 low-power tick, 2 rtc event
  task automatic pop_run(input int src, input int stall_pct);
    logic        prev_stall;
    logic [15:0] prev_data;
    got_n = 0;
    case (src)
      0: sw_pop = 1;
      1: lp_tick = 1;
      default: rtc_evt = 1;
    endcase
    @(negedge clk);
    sw_pop = 0; lp_tick = 0; rtc_evt = 0;
    prev_stall = 0; prev_data = 0;
    for (int k = 0; k < 200; k++) begin
      if (!cmd_valid) break;
      if (prev_stall) check(cmd_data == prev_data, "R12 stalled data", cmd_data, prev_data);
      cmd_ready = ($urandom_range(99) >= stall_pct);
      if (cmd_ready) begin
        got[got_n] = cmd_data;
        got_n++;
      end
      prev_stall = !cmd_ready;
      prev_data  = cmd_data;
      @(negedge clk);
    end
    cmd_ready = 0;
  endtask

  initial begin
    #(40000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    do_reset();

    // R11 reset state
    check(rd_ptr == 0 && wr_ptr == 0, "R11 pointers", {rd_ptr, wr_ptr}, 0);
    check(irq_status == 0 && !irq, "R11 status", irq_status, 0);
    check(!cmd_valid, "R11 cmd_valid", cmd_valid, 0);

    // R1 random push/pop with stalls (R12 checked inside pop_run)
    for (int it = 0; it < 120; it++) begin
      if (($urandom_range(1) == 1 && model.size() < DEPTH) || model.size() == 0) begin
        logic [15:0] d;
        d = 16'($urandom_range(16'h1fff));
        push(d);
        model.push_back(d);
      end else begin
        logic [5:0] rp0;
        logic [15:0] e;
        rp0 = rd_ptr;
        pop_run(0, 40);
        e = model.pop_front();
        check(got_n == 1, "R1 single pop count", got_n, 1);
        check(got[0] == e, "R1 order", got[0], e);
        check(rd_ptr == rp0 + 6'd1, "R12 pointer moves once", rd_ptr, rp0 + 6'd1);
      end
    end
    check(6'(wr_ptr - rd_ptr) == 6'(model.size()), "R1 level", wr_ptr - rd_ptr, model.size());

    // R4 multi-command launch
    do_reset();
    push(16'h4011); push(16'hE022); push(16'hA033); push(16'h0044);
    pop_run(0, 30);
    check(got_n == burst_len(16'h4011), "R4 launch length", got_n, burst_len(16'h4011));
    check(got[0] == 16'h4011 && got[2] == 16'hA033, "R4 launch data", got[2], 16'hA033);
    check(rd_ptr == 3, "R4 rd_ptr", rd_ptr, 3);
    pop_run(0, 0);
    check(got_n == 1 && got[0] == 16'h0044, "R4 follow-up launch", got[0], 16'h0044);

    // R3 underrun on empty, and on an over-long launch
    irq_en = 5'b00010;
    pop_run(0, 0);
    check(got_n == 0, "R3 empty launch", got_n, 0);
    check(irq_status[1] == 1 && irq, "R3 underrun status", irq_status, 2);
    irq_clr = 5'b00010; @(negedge clk); irq_clr = 0;
    check(irq_status[1] == 0, "R10 clear underrun", irq_status, 0);
    push(16'h6055);
    pop_run(0, 0);
    check(got_n == 1, "R3 short launch", got_n, 1);
    @(negedge clk);
    check(irq_status[1] == 1, "R3 over-long launch", irq_status, 2);

    // R2 overflow and R10 set-wins
    do_reset();
    irq_en = 5'b00001;
    for (int i = 0; i < DEPTH; i++) push(16'(16'h0100 + i));
    check(push_ready == 0, "R2 push_ready low", push_ready, 0);
    push(16'hBEEF);
    check(wr_ptr == 6'd32, "R2 wr_ptr held", wr_ptr, 32);
    check(irq_status[0] == 1, "R2 overflow status", irq_status, 1);
    push_valid = 1; push_data = 16'hBEEF; irq_clr = 5'b00001;
    @(negedge clk);
    push_valid = 0; irq_clr = 0;
    check(irq_status[0] == 1, "R10 set wins", irq_status, 1);
    irq_clr = 5'b00001; @(negedge clk); irq_clr = 0;
    check(irq_status[0] == 0, "R10 clear", irq_status, 0);
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        pop_run(0, 0);
        if (got_n != 1 || got[0] != 16'(16'h0100 + i)) bad++;
      end
      check(bad == 0, "R2 contents intact", bad, 0);
    end

    // R8 threshold
    do_reset();
    thr_level = 2; irq_en = 5'b00100;
    @(negedge clk);
    check(irq_status[2] == 1, "R8 empty below threshold", irq_status, 4);
    push(16'h0001); push(16'h0002); push(16'h0003);
    irq_clr = 5'b00100; @(negedge clk); irq_clr = 0;
    check(irq_status[2] == 0, "R8 level above threshold", irq_status, 0);
    pop_run(0, 0);
    @(negedge clk);
    check(irq_status[2] == 1, "R8 level at threshold", irq_status, 4);

    // R5 trigger gating
    do_reset();
    push(16'h0A01); push(16'h0A02);
    pop_run(1, 0);
    check(got_n == 0 && rd_ptr == 0, "R5 lp tick gated", rd_ptr, 0);
    pop_run(2, 0);
    check(got_n == 0 && rd_ptr == 0, "R5 rtc gated", rd_ptr, 0);
    lp_trig_en = 1;
    pop_run(1, 0);
    check(got_n == 1 && got[0] == 16'h0A01, "R5 lp tick launch", got[0], 16'h0A01);
    rtc_trig_en = 1;
    pop_run(2, 0);
    check(got_n == 1 && got[0] == 16'h0A02, "R5 rtc launch", got[0], 16'h0A02);

    // R7 pointer load
    do_reset();
    wp_wdata = 6'd5; wp_wr = 1; @(negedge clk); wp_wr = 0;
    check(wr_ptr == 0, "R7 plain mode load ignored", wr_ptr, 0);
    cyc_mode = 1;
    wp_wr = 1; @(negedge clk); wp_wr = 0;
    check(wr_ptr == 5, "R7 ring mode load", wr_ptr, 5);

    // R6 ring replay
    do_reset();
    cyc_mode = 1; cyc_size = 7'd3; irq_en = 5'b00010;
    push(16'h1111); push(16'h1222); push(16'h1333);
    check(wr_ptr == 0, "R6 wr_ptr wraps", wr_ptr, 0);
    begin
      logic [15:0] ring [0:2];
      int bad = 0;
      ring[0] = 16'h1111; ring[1] = 16'h1222; ring[2] = 16'h1333;
      for (int i = 0; i < 5; i++) begin
        pop_run(0, 20);
        if (got_n != 1 || got[0] != ring[i % 3]) bad++;
      end
      check(bad == 0, "R6 replay order", bad, 0);
    end
    check(rd_ptr == 2, "R6 rd_ptr after replay", rd_ptr, 2);
    check(irq_status[1] == 0, "R6 no underrun", irq_status, 0);

    // R9 generator events
    do_reset();
    irq_en = 5'b01000; gen_start_msk = 5'b00100; gen_end_msk = 5'b00001;
    gen_start = 5'b00010; @(negedge clk); gen_start = 0;
    check(irq_status[3] == 0, "R9 masked start", irq_status, 0);
    gen_start = 5'b00100; @(negedge clk); gen_start = 0;
    check(irq_status[3] == 1, "R9 start", irq_status, 8);
    gen_end = 5'b00001; @(negedge clk); gen_end = 0;
    check(irq_status[4] == 0, "R9 end disabled", irq_status, 8);
    irq_en = 5'b10000;
    gen_end = 5'b00001; @(negedge clk); gen_end = 0;
    check(irq_status[4] == 1 && irq, "R9 end", irq_status, 24);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule